// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This unit sits next to a small processor and decides which of eight device request lines gets served next. Software sets up each device through a register write port. A device has an enable bit, a two-bit priority, a handler vector address and an identification number. Request lines from enabled devices are caught in a pending register. A combinational pick then shows the processor the best request that may interrupt the work now running. It drives a pending flag, the winning device's identification number, and the vector that the processor uses as its jump target. The processor saves its return address itself.

When the processor accepts an interrupt with an acknowledge, the served pending bit is cleared. The current service level goes onto a small stack, and the winner's priority becomes the new level. While a handler runs, only requests of strictly higher priority can reach the processor, so handlers nest. An end-of-interrupt pops the stack and restores the earlier level. Both entry and exit give a one-cycle strobe that tells the processor to switch register banks.

The control state machine has two states. `ST_IDLE` means no handler is running and the level is 0. `ST_SERVE` means at least one handler is running. It has four transitions:
- `T_ENTER`: IDLE→SERVE on an accepted acknowledge.
- `T_NEST`: SERVE→SERVE on an accepted acknowledge.
- `T_UNNEST`: SERVE→SERVE on an end-of-interrupt while more than one level is stacked.
- `T_LEAVE`: SERVE→IDLE on an end-of-interrupt with one level stacked.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every device is disabled, with priority 0, vector 0 and an identification number equal to its device index. No request is pending, the level is 0, and `irq_pending` and `bank_swap` are low.
- R2: A write with `cfg_we` high uses `cfg_addr[4:2]` as the device and `cfg_addr[1:0]` as the field. Field 0 is the enable (`cfg_wdata[0]`), 1 the priority (`cfg_wdata[1:0]`), 2 the vector (`cfg_wdata[11:0]`) and 3 the identification number (`cfg_wdata[7:0]`). The write takes effect from the next cycle.
- R3: A request line that is high at a clock edge sets its device's pending bit only if that device is enabled. The bit stays set after the line drops, until the device is acknowledged. A request from a disabled device is not kept, so enabling the device later does not bring it up.
- R4: `irq_pending` is high exactly when some pending, enabled device has a priority strictly greater than the current level. The winner has the highest priority, and the lowest device number breaks ties. `irq_id` and `irq_vector` show the winner's registers, and are zero when nothing is pending. Priority 0 never wins.
- R5: An acknowledge is accepted when `irq_ack` and `irq_pending` are high and `irq_eoi` is low. It clears the winner's pending bit, pushes the current level and raises the level to the winner's priority. An acknowledge with nothing pending has no effect.
- R6: While a handler is active, `irq_eoi` restores the level that was active before the most recent accepted acknowledge. When no handler is active, `irq_eoi` has no effect.
- R7: When `irq_ack` and `irq_eoi` are high in the same cycle, the acknowledge is ignored and only the end-of-interrupt acts.
- R8: `bank_swap` is high for exactly one cycle after every accepted acknowledge and every end-of-interrupt that acts, and is low at all other times.
- R9: Handlers nest three deep (levels 1, 2 and 3) and unwind in reverse order. Each end-of-interrupt brings back the masking of the level below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Per-device request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Device (bits 4:2) and field (bits 1:0) select |
| cfg_wdata | input | 12 | Configuration write data |
| irq_ack | input | 1 | Processor accepts the shown interrupt |
| irq_eoi | input | 1 | Handler has finished |
| irq_pending | output | 1 | A request may interrupt the current level |
| irq_id | output | 8 | Identification number of the winner |
| irq_vector | output | 12 | Handler address of the winner |
| bank_swap | output | 1 | One-cycle register bank switch strobe |

## Verification
The checks assume that the processor raises the acknowledge only as a single-cycle pulse, and that end-of-interrupt arrives the same way. They also assume no end-of-interrupt comes without an earlier entry, apart from the deliberate idle cases. Because levels rise strictly with each accepted acknowledge, the three-entry stack can never overflow, and an assertion relies on this. The stimulus gives one-cycle pulses on every control input and drops each request line before it acknowledges. This keeps the clear-versus-set case out of the scoreboard's expected values, while the assertions still cover it.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PIC_DEVICES   = 8;
    localparam int PIC_PRIO_W    = 2;
    localparam int PIC_VEC_W     = 12;
    localparam int PIC_ID_W      = 8;
    localparam int PIC_STK_DEPTH = 3;

    typedef enum logic [1:0] {
        FLD_EN   = 2'd0,
        FLD_PRIO = 2'd1,
        FLD_VEC  = 2'd2,
        FLD_ID   = 2'd3
    } cfg_fld_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } pic_state_e;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int N_DEV  = PIC_DEVICES,
    parameter int PRIO_W = PIC_PRIO_W,
    parameter int VEC_W  = PIC_VEC_W,
    parameter int ID_W   = PIC_ID_W,
    parameter int ADDR_W = $clog2(PIC_DEVICES) + 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [VEC_W-1:0]             wdata,
    output logic [N_DEV-1:0]             en_o,
    output logic [N_DEV-1:0][PRIO_W-1:0] prio_o,
    output logic [N_DEV-1:0][VEC_W-1:0]  vec_o,
    output logic [N_DEV-1:0][ID_W-1:0]   id_o
);
    localparam int DEV_W = ADDR_W - 2;

    cfg_fld_e fld;
    assign fld = cfg_fld_e'(addr[1:0]);

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        logic hit;
        assign hit = we && (addr[ADDR_W-1:2] == DEV_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_o[g]   <= 1'b0;
                prio_o[g] <= '0;
                vec_o[g]  <= '0;
                id_o[g]   <= ID_W'(g);
            end else if (hit) begin
                unique case (fld)
                    FLD_EN:   en_o[g]   <= wdata[0];
                    FLD_PRIO: prio_o[g] <= wdata[PRIO_W-1:0];
                    FLD_VEC:  vec_o[g]  <= wdata;
                    FLD_ID:   id_o[g]   <= wdata[ID_W-1:0];
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_pick.sv
module pic_pick #(
    parameter int N_DEV  = 8,
    parameter int PRIO_W = 2,
    parameter int DEV_W  = 3
) (
    input  logic [N_DEV-1:0]             cand,
    input  logic [N_DEV-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]            floor_lvl,
    output logic                         hit,
    output logic [DEV_W-1:0]             idx,
    output logic [PRIO_W-1:0]            best
);
    // Strict compare keeps the lowest index on ties and rejects the floor level.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = floor_lvl;
        for (int i = 0; i < N_DEV; i++) begin
            if (cand[i] && (prio[i] > best)) begin
                hit  = 1'b1;
                idx  = DEV_W'(i);
                best = prio[i];
            end
        end
    end
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack #(
    parameter int PRIO_W = 2,
    parameter int DEPTH  = 3,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] din,
    output logic [PRIO_W-1:0] top_o,
    output logic [CNT_W-1:0]  depth_o
);
    logic [PRIO_W-1:0] slot_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (pop && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end else if (push && (cnt_q < CNT_W'(DEPTH))) begin
            slot_q[cnt_q] <= din;
            cnt_q         <= cnt_q + CNT_W'(1);
        end
    end

    assign top_o   = (cnt_q != '0) ? slot_q[cnt_q - CNT_W'(1)] : '0;
    assign depth_o = cnt_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_DEV     = PIC_DEVICES,
    parameter int PRIO_W    = PIC_PRIO_W,
    parameter int VEC_W     = PIC_VEC_W,
    parameter int ID_W      = PIC_ID_W,
    parameter int STK_DEPTH = PIC_STK_DEPTH,
    localparam int DEV_W    = $clog2(N_DEV),
    localparam int ADDR_W   = DEV_W + 2,
    localparam int LVL_CW   = $clog2(STK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DEV-1:0]  irq_req,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [VEC_W-1:0]  cfg_wdata,
    input  logic              irq_ack,
    input  logic              irq_eoi,
    output logic              irq_pending,
    output logic [ID_W-1:0]   irq_id,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              bank_swap
);
    logic [N_DEV-1:0]             en_q;
    logic [N_DEV-1:0][PRIO_W-1:0] prio_q;
    logic [N_DEV-1:0][VEC_W-1:0]  vec_q;
    logic [N_DEV-1:0][ID_W-1:0]   id_q;
    logic [N_DEV-1:0]             pend_q;
    logic [N_DEV-1:0]             clr_mask;
    logic [PRIO_W-1:0]            level_q;
    logic [PRIO_W-1:0]            stk_top;
    logic [LVL_CW-1:0]            stk_depth;
    logic                         win_hit;
    logic [DEV_W-1:0]             win_idx;
    logic [PRIO_W-1:0]            win_prio;
    logic                         take_ack;
    logic                         take_eoi;
    logic                         swap_q;
    pic_state_e                   state_q, state_d;

    pic_cfg_regs #(
        .N_DEV(N_DEV), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .ID_W(ID_W), .ADDR_W(ADDR_W)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .en_o(en_q), .prio_o(prio_q), .vec_o(vec_q), .id_o(id_q)
    );

    pic_pick #(
        .N_DEV(N_DEV), .PRIO_W(PRIO_W), .DEV_W(DEV_W)
    ) i_pick (
        .cand(pend_q & en_q), .prio(prio_q), .floor_lvl(level_q),
        .hit(win_hit), .idx(win_idx), .best(win_prio)
    );

    pic_level_stack #(
        .PRIO_W(PRIO_W), .DEPTH(STK_DEPTH), .CNT_W(LVL_CW)
    ) i_stk (
        .clk(clk), .rst_n(rst_n), .push(take_ack), .pop(take_eoi),
        .din(level_q), .top_o(stk_top), .depth_o(stk_depth)
    );

    // End-of-interrupt outranks acknowledge in the same cycle.
    assign take_eoi = irq_eoi && (state_q == ST_SERVE);
    assign take_ack = irq_ack && win_hit && !irq_eoi;

    always_comb begin
        clr_mask = '0;
        if (take_ack) clr_mask[win_idx] = 1'b1;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_ack) state_d = ST_SERVE;                 // T_ENTER
            end
            ST_SERVE: begin
                if (take_eoi && (stk_depth == LVL_CW'(1)))
                    state_d = ST_IDLE;                            // T_LEAVE
                else
                    state_d = ST_SERVE;                           // T_NEST / T_UNNEST
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            level_q <= '0;
            swap_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= (pend_q | (irq_req & en_q)) & ~clr_mask;
            swap_q  <= take_ack || take_eoi;
            if (take_eoi)      level_q <= stk_top;
            else if (take_ack) level_q <= win_prio;
        end
    end

    // Output process.
    always_comb begin
        irq_pending = win_hit;
        irq_id      = win_hit ? id_q[win_idx]  : '0;
        irq_vector  = win_hit ? vec_q[win_idx] : '0;
        bank_swap   = swap_q;
    end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int N_DEV     = 8,
    parameter int PRIO_W    = 2,
    parameter int STK_DEPTH = 3,
    parameter int DEV_W     = 3,
    parameter int LVL_CW    = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         irq_ack,
    input logic                         irq_eoi,
    input logic                         irq_pending,
    input logic                         bank_swap,
    input logic [N_DEV-1:0]             en_q,
    input logic [N_DEV-1:0]             pend_q,
    input logic [N_DEV-1:0][PRIO_W-1:0] prio_q,
    input logic [DEV_W-1:0]             win_idx,
    input logic [PRIO_W-1:0]            level_q,
    input logic [LVL_CW-1:0]            stk_depth
);
    logic acc;
    assign acc = irq_ack && irq_pending && !irq_eoi;

    p_pend_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (en_q[win_idx] && pend_q[win_idx]));

    p_above_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (prio_q[win_idx] > level_q));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !pend_q[$past(win_idx)]);

    p_ack_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (level_q == $past(prio_q[win_idx])));

    p_eoi_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_eoi && (stk_depth == '0)) |=> (!bank_swap && (level_q == '0)));

    p_swap_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> bank_swap);

    p_swap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_ack && !irq_eoi) |=> !bank_swap);

    p_stack_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (stk_depth < LVL_CW'(STK_DEPTH)));
endmodule

bind prio_irq_ctrl pic_chk #(
    .N_DEV(N_DEV), .PRIO_W(PRIO_W), .STK_DEPTH(STK_DEPTH), .DEV_W(DEV_W), .LVL_CW(LVL_CW)
) i_chk (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_eoi(irq_eoi),
    .irq_pending(irq_pending), .bank_swap(bank_swap), .en_q(en_q), .pend_q(pend_q),
    .prio_q(prio_q), .win_idx(win_idx), .level_q(level_q), .stk_depth(stk_depth)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_req = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        irq_ack = 1'b0;
    logic        irq_eoi = 1'b0;
    logic        irq_pending;
    logic [7:0]  irq_id;
    logic [11:0] irq_vector;
    logic        bank_swap;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        bit entry;
        int id;
        int vec;
    } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_ack(irq_ack),
        .irq_eoi(irq_eoi), .irq_pending(irq_pending), .irq_id(irq_id),
        .irq_vector(irq_vector), .bank_swap(bank_swap)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic align();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input int dev, input int fld, input int data);
        align();
        cfg_we = 1'b1; cfg_addr = 5'((dev << 2) | fld); cfg_wdata = 12'(data);
        align();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req(input logic [7:0] m);
        align();
        irq_req = m;
        align();
        irq_req = '0;
    endtask

    task automatic do_ack(input int eid, input int evec);
        item_t it;
        it.entry = 1'b1; it.id = eid; it.vec = evec;
        align();
        exp_q.push_back(it);
        irq_ack = 1'b1;
        align();
        irq_ack = 1'b0;
    endtask

    task automatic do_eoi(input bit acts);
        item_t it;
        it.entry = 1'b0; it.id = 0; it.vec = 0;
        align();
        if (acts) exp_q.push_back(it);
        irq_eoi = 1'b1;
        align();
        irq_eoi = 1'b0;
    endtask

    task automatic expect_out(input string tag, input bit p, input int eid, input int evec);
        @(negedge clk);
        chk(irq_pending == p, tag, int'(irq_pending), int'(p));
        if (p) begin
            chk(int'(irq_id) == eid, tag, int'(irq_id), eid);
            chk(int'(irq_vector) == evec, tag, int'(irq_vector), evec);
        end
    endtask

    // Monitor: pops one expected item for every strobe the design produces.
    initial begin
        bit prev_acc = 1'b0;
        int obs_id = 0;
        int obs_vec = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_acc = 1'b0;
            end else begin
                if (bank_swap) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected strobe", 1, 0);
                    end else begin
                        item_t it;
                        it = exp_q.pop_front();
                        chk(it.entry == prev_acc, "R8 strobe kind", int'(prev_acc), int'(it.entry));
                        if (it.entry) begin
                            chk(obs_id == it.id, "R4 acked id", obs_id, it.id);
                            chk(obs_vec == it.vec, "R4 acked vector", obs_vec, it.vec);
                        end
                    end
                end
                prev_acc = irq_ack && irq_pending && !irq_eoi;
                if (prev_acc) begin
                    obs_id = int'(irq_id);
                    obs_vec = int'(irq_vector);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) align();
        rst_n = 1'b1;

        // R1: reset state
        expect_out("R1 reset pending", 1'b0, 0, 0);
        chk(bank_swap == 1'b0, "R1 reset strobe", int'(bank_swap), 0);

        // R3: disabled device request is not kept
        cfg(3, 1, 1); cfg(3, 2, 'h130);
        pulse_req(8'h08);
        expect_out("R3 disabled request", 1'b0, 0, 0);
        cfg(3, 0, 1);
        expect_out("R3 no stale request", 1'b0, 0, 0);
        // R1 reset id equals index, R2 vector write, R3 latched after drop
        pulse_req(8'h08);
        expect_out("R1 R2 R3 single request", 1'b1, 3, 'h130);
        do_ack(3, 'h130);
        expect_out("R5 pending cleared", 1'b0, 0, 0);
        do_eoi(1'b1);

        cfg(2, 0, 1); cfg(2, 1, 1); cfg(2, 2, 'h200); cfg(2, 3, 'h42);
        cfg(5, 0, 1); cfg(5, 1, 3); cfg(5, 2, 'h5A5); cfg(5, 3, 'h55);
        cfg(4, 0, 1); cfg(4, 1, 2); cfg(4, 2, 'h404); cfg(4, 3, 'h44);
        cfg(6, 0, 1); cfg(6, 1, 2); cfg(6, 2, 'h606); cfg(6, 3, 'h66);
        cfg(7, 0, 1); cfg(7, 1, 0); cfg(7, 2, 'h777); cfg(7, 3, 'h77);
        cfg(0, 0, 1); cfg(0, 1, 1); cfg(0, 2, 'h010); cfg(0, 3, 'h10);

        // R4: higher priority wins
        pulse_req(8'h24);
        expect_out("R4 high beats low", 1'b1, 'h55, 'h5A5);
        do_ack('h55, 'h5A5);
        expect_out("R4 low blocked by level", 1'b0, 0, 0);
        do_eoi(1'b1);
        expect_out("R6 level restored", 1'b1, 'h42, 'h200);
        do_ack('h42, 'h200);
        do_eoi(1'b1);

        // R4: tie broken by lowest device number
        pulse_req(8'h50);
        expect_out("R4 tie lowest index", 1'b1, 'h44, 'h404);
        do_ack('h44, 'h404);
        expect_out("R4 equal level blocked", 1'b0, 0, 0);
        do_eoi(1'b1);
        expect_out("R6 tie loser appears", 1'b1, 'h66, 'h606);
        do_ack('h66, 'h606);
        do_eoi(1'b1);

        // R4: priority 0 never wins
        pulse_req(8'h80);
        expect_out("R4 priority zero", 1'b0, 0, 0);

        // R9: three-deep nesting
        pulse_req(8'h01);
        expect_out("R9 level1 entry", 1'b1, 'h10, 'h010);
        do_ack('h10, 'h010);
        pulse_req(8'h10);
        expect_out("R9 level2 entry", 1'b1, 'h44, 'h404);
        do_ack('h44, 'h404);
        pulse_req(8'h04);
        expect_out("R9 low blocked at level2", 1'b0, 0, 0);
        pulse_req(8'h20);
        expect_out("R9 level3 entry", 1'b1, 'h55, 'h5A5);
        do_ack('h55, 'h5A5);
        do_eoi(1'b1);
        expect_out("R9 back to level2", 1'b0, 0, 0);
        do_eoi(1'b1);
        expect_out("R9 back to level1", 1'b0, 0, 0);
        do_eoi(1'b1);
        expect_out("R9 back to level0", 1'b1, 'h42, 'h200);
        do_ack('h42, 'h200);
        do_eoi(1'b1);

        // R6: end-of-interrupt while idle is ignored
        do_eoi(1'b0);
        expect_out("R6 idle eoi", 1'b0, 0, 0);
        chk(bank_swap == 1'b0, "R6 idle eoi strobe", int'(bank_swap), 0);

        // R7: ack with eoi in the same cycle, idle
        pulse_req(8'h10);
        align();
        irq_ack = 1'b1; irq_eoi = 1'b1;
        align();
        irq_ack = 1'b0; irq_eoi = 1'b0;
        expect_out("R7 ack ignored idle", 1'b1, 'h44, 'h404);
        do_ack('h44, 'h404);
        // R7: ack with eoi while serving, eoi acts
        pulse_req(8'h20);
        expect_out("R7 nested candidate", 1'b1, 'h55, 'h5A5);
        begin
            item_t it;
            it.entry = 1'b0; it.id = 0; it.vec = 0;
            align();
            exp_q.push_back(it);
            irq_ack = 1'b1; irq_eoi = 1'b1;
            align();
            irq_ack = 1'b0; irq_eoi = 1'b0;
        end
        expect_out("R7 request kept", 1'b1, 'h55, 'h5A5);
        do_ack('h55, 'h5A5);
        do_eoi(1'b1);

        // R5: ack with nothing pending
        align();
        irq_ack = 1'b1;
        align();
        irq_ack = 1'b0;
        @(negedge clk);
        chk(bank_swap == 1'b0, "R5 ack without pending", int'(bank_swap), 0);

        // R2: rewrite vector, then disable
        cfg(4, 2, 'h0AB);
        pulse_req(8'h10);
        expect_out("R2 new vector", 1'b1, 'h44, 'h0AB);
        do_ack('h44, 'h0AB);
        do_eoi(1'b1);
        cfg(4, 0, 0);
        pulse_req(8'h10);
        expect_out("R2 disable write", 1'b0, 0, 0);

        repeat (3) align();
        chk(exp_q.size() == 0, "R8 missing strobes", exp_q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule